// File: doc/BRIEF.md
# Conditional Byte-Order Converter

This block carries out the byte-swap operation of a packet-filter instruction set's arithmetic unit. For each accepted operation it takes a 64-bit destination value and a few instruction fields. Those fields are the arithmetic code, a class bit that picks 32-bit or 64-bit arithmetic, the one-bit source field and the 32-bit immediate. The block produces the converted destination one clock later, together with a flag that marks an illegal encoding.

In the 32-bit class the source bit names a target byte order: 0 selects little endian and 1 selects big endian. The bytes are reversed only when that order differs from the host byte order, which a build-time parameter fixes. The 64-bit class always reverses the bytes. The immediate selects how many low bytes take part. The result is always cut to that width and zero-extended to 64 bits, whether or not a reversal happened. When the arithmetic code is not the byte-swap code, the destination passes through unchanged.

Top module: `byteorder_conv`

## Requirements
- R1: After reset, `out_valid`, `illegal` and `dst_out` are all 0.
- R2: Each cycle with `in_valid` high produces `out_valid` high on the next clock edge, and `dst_out`/`illegal` for that operation appear at that edge. A cycle with `in_valid` low produces `out_valid` low on the next edge.
- R3: When the class is 32-bit (`is_alu64`=0) and `src_bit` is 0 (little endian), the bytes are reversed only if `HOST_BIG_ENDIAN`=1. Otherwise the value is only truncated to the width and zero-extended.
- R4: When the class is 32-bit and `src_bit` is 1 (big endian), the bytes are reversed only if `HOST_BIG_ENDIAN`=0. Otherwise the value is only truncated and zero-extended.
- R5: When the class is 64-bit (`is_alu64`=1) and `src_bit` is 0, the bytes are always reversed, whatever the value of `HOST_BIG_ENDIAN`.
- R6: An immediate of 16 reverses bytes 0..1, and an immediate of 32 reverses bytes 0..3. In both cases all result bits at or above the width are cleared.
- R7: An immediate of 64 reverses all eight bytes. Byte k of the result is byte 7-k of the input.
- R8: With `op_code` equal to the swap code (default 0xd), any immediate other than 16, 32 or 64 sets `illegal` to 1, and `dst_out` equals the unmodified `dst_in`.
- R9: With `op_code` equal to the swap code, `is_alu64`=1 together with `src_bit`=1 sets `illegal` to 1, and `dst_out` equals the unmodified `dst_in`.
- R10: When `op_code` is not the swap code, `dst_out` equals `dst_in` and `illegal` is 0, whatever the other fields hold.
- R11: When `in_valid` is low, `dst_out` and `illegal` keep the values they had from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| in_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Arithmetic operation code |
| is_alu64 | input | 1 | 1 = 64-bit arithmetic class, 0 = 32-bit class |
| src_bit | input | 1 | Source field: target byte order in the 32-bit class |
| imm | input | 32 | Swap width in bits |
| dst_in | input | 64 | Destination value before the operation |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| dst_out | output | 64 | Converted destination value |
| illegal | output | 1 | Encoding of the operation was not legal |

## Verification
The clocked properties assume that `in_valid`, `op_code`, `is_alu64`, `src_bit`, `imm` and `dst_in` settle to known values before each rising edge once reset is released. They also assume that a result is judged only in the cycle after its operation was accepted. The stimulus changes every input on the falling clock edge and drops `in_valid` between directed operations, except in the back-to-back case. It reads the outputs on the following falling edge, so each reading falls inside the one-cycle window that the properties describe. Two copies of the block, one built for each host byte order, receive the same stimulus, which covers both sides of the order comparison.

// File: rtl/byteorder_pkg.sv
package byteorder_pkg;

    localparam int WORD_W  = 64;
    localparam int BYTE_W  = 8;
    localparam int NBYTES  = WORD_W / BYTE_W;

    typedef enum logic [1:0] {
        WSEL_16  = 2'd0,
        WSEL_32  = 2'd1,
        WSEL_64  = 2'd2,
        WSEL_BAD = 2'd3
    } width_sel_e;

    typedef struct packed {
        logic              valid;
        logic              illegal;
        logic [WORD_W-1:0] data;
    } conv_state_t;

endpackage

// File: rtl/bo_width_decoder.sv
module bo_width_decoder
    import byteorder_pkg::*;
#(
    parameter int IMM_W = 32
) (
    input  logic [IMM_W-1:0] imm,
    output width_sel_e       wsel
);

    always_comb begin
        if (imm == IMM_W'(16))
            wsel = WSEL_16;
        else if (imm == IMM_W'(32))
            wsel = WSEL_32;
        else if (imm == IMM_W'(64))
            wsel = WSEL_64;
        else
            wsel = WSEL_BAD;
    end

endmodule

// File: rtl/bo_order_select.sv
module bo_order_select #(
    parameter bit HOST_BIG_ENDIAN = 1'b0
) (
    input  logic is_alu64,
    input  logic src_bit,
    output logic do_swap,
    output logic reserved_bad
);

    always_comb begin
        if (is_alu64) begin
            // wide class reverses unconditionally; its source bit is reserved
            do_swap      = 1'b1;
            reserved_bad = src_bit;
        end else begin
            // narrow class: reverse only when target order differs from host
            do_swap      = (src_bit != HOST_BIG_ENDIAN);
            reserved_bad = 1'b0;
        end
    end

endmodule

// File: rtl/bo_swap_unit.sv
module bo_swap_unit
    import byteorder_pkg::*;
(
    input  logic [WORD_W-1:0] data_in,
    input  width_sel_e        wsel,
    input  logic              do_swap,
    output logic [WORD_W-1:0] data_out
);

    localparam int HALF_B    = NBYTES / 2;
    localparam int QUARTER_B = NBYTES / 4;

    logic [WORD_W-1:0] rev_full;
    logic [WORD_W-1:0] rev_half;
    logic [WORD_W-1:0] rev_quarter;

    genvar b;
    generate
        for (b = 0; b < NBYTES; b++) begin : g_full
            assign rev_full[b*BYTE_W +: BYTE_W] = data_in[(NBYTES-1-b)*BYTE_W +: BYTE_W];
        end
        for (b = 0; b < NBYTES; b++) begin : g_half
            if (b < HALF_B) begin : g_in
                assign rev_half[b*BYTE_W +: BYTE_W] = data_in[(HALF_B-1-b)*BYTE_W +: BYTE_W];
            end else begin : g_out
                assign rev_half[b*BYTE_W +: BYTE_W] = '0;
            end
        end
        for (b = 0; b < NBYTES; b++) begin : g_quarter
            if (b < QUARTER_B) begin : g_in
                assign rev_quarter[b*BYTE_W +: BYTE_W] = data_in[(QUARTER_B-1-b)*BYTE_W +: BYTE_W];
            end else begin : g_out
                assign rev_quarter[b*BYTE_W +: BYTE_W] = '0;
            end
        end
    endgenerate

    always_comb begin
        unique case (wsel)
            WSEL_16: data_out = do_swap ? rev_quarter
                                        : {{(WORD_W-QUARTER_B*BYTE_W){1'b0}}, data_in[QUARTER_B*BYTE_W-1:0]};
            WSEL_32: data_out = do_swap ? rev_half
                                        : {{(WORD_W-HALF_B*BYTE_W){1'b0}}, data_in[HALF_B*BYTE_W-1:0]};
            WSEL_64: data_out = do_swap ? rev_full : data_in;
            default: data_out = data_in;
        endcase
    end

endmodule

// File: rtl/byteorder_conv.sv
module byteorder_conv
    import byteorder_pkg::*;
#(
    parameter bit          HOST_BIG_ENDIAN = 1'b0,
    parameter int          OP_W            = 4,
    parameter int          IMM_W           = 32,
    parameter logic [OP_W-1:0] SWAP_CODE   = 4'hd
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op_code,
    input  logic              is_alu64,
    input  logic              src_bit,
    input  logic [IMM_W-1:0]  imm,
    input  logic [WORD_W-1:0] dst_in,
    output logic              out_valid,
    output logic [WORD_W-1:0] dst_out,
    output logic              illegal
);

    width_sel_e        wsel;
    logic              do_swap;
    logic              reserved_bad;
    logic [WORD_W-1:0] swapped;
    conv_state_t       state_d;
    conv_state_t       state_q;

    bo_width_decoder #(.IMM_W(IMM_W)) u_wdec (
        .imm  (imm),
        .wsel (wsel)
    );

    bo_order_select #(.HOST_BIG_ENDIAN(HOST_BIG_ENDIAN)) u_osel (
        .is_alu64     (is_alu64),
        .src_bit      (src_bit),
        .do_swap      (do_swap),
        .reserved_bad (reserved_bad)
    );

    bo_swap_unit u_swap (
        .data_in  (dst_in),
        .wsel     (wsel),
        .do_swap  (do_swap),
        .data_out (swapped)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) begin
            if (op_code != SWAP_CODE) begin
                state_d.data    = dst_in;
                state_d.illegal = 1'b0;
            end else if (reserved_bad || (wsel == WSEL_BAD)) begin
                state_d.data    = dst_in;
                state_d.illegal = 1'b1;
            end else begin
                state_d.data    = swapped;
                state_d.illegal = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign out_valid = state_q.valid;
    assign dst_out   = state_q.data;
    assign illegal   = state_q.illegal;

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(dst_out) && $stable(illegal)));

    // R9
    reserved_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == SWAP_CODE && is_alu64 && src_bit)
        |=> (illegal && dst_out == $past(dst_in)));

    // R10
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code != SWAP_CODE) |=> (!illegal && dst_out == $past(dst_in)));

    // R6
    narrow_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == SWAP_CODE && imm == IMM_W'(16) && !(is_alu64 && src_bit))
        |=> (dst_out[WORD_W-1:16] == '0 && !illegal));

    // R8
    bad_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == SWAP_CODE && imm != IMM_W'(16) && imm != IMM_W'(32)
         && imm != IMM_W'(64)) |=> illegal);

endmodule

// File: tb/byteorder_conv_test.sv
`timescale 1ns/1ps
module byteorder_conv_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_code = 4'h0;
    logic        is_alu64 = 1'b0;
    logic        src_bit = 1'b0;
    logic [31:0] imm = 32'd0;
    logic [63:0] dst_in = 64'd0;

    logic        le_valid, be_valid, le_ill, be_ill;
    logic [63:0] le_dst, be_dst;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    byteorder_conv #(.HOST_BIG_ENDIAN(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .is_alu64(is_alu64), .src_bit(src_bit), .imm(imm), .dst_in(dst_in),
        .out_valid(le_valid), .dst_out(le_dst), .illegal(le_ill)
    );

    byteorder_conv #(.HOST_BIG_ENDIAN(1'b1)) uut_be (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .is_alu64(is_alu64), .src_bit(src_bit), .imm(imm), .dst_in(dst_in),
        .out_valid(be_valid), .dst_out(be_dst), .illegal(be_ill)
    );

    // expected {illegal, value} from the requirement text
    function automatic logic [64:0] expect_of(bit host_be, logic [3:0] op, bit a64,
                                              bit src, logic [31:0] im, logic [63:0] d);
        int nb;
        bit sw;
        logic [63:0] r;
        if (op != 4'hd) return {1'b0, d};
        if (a64 && src) return {1'b1, d};
        if (im == 32'd16) nb = 2;
        else if (im == 32'd32) nb = 4;
        else if (im == 32'd64) nb = 8;
        else return {1'b1, d};
        sw = a64 ? 1'b1 : (src != host_be);
        r = '0;
        for (int k = 0; k < nb; k++)
            r[k*8 +: 8] = sw ? d[(nb-1-k)*8 +: 8] : d[k*8 +: 8];
        return {1'b0, r};
    endfunction

    task automatic check(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic drive(logic [3:0] op, bit a64, bit src, logic [31:0] im, logic [63:0] d);
        @(negedge clk);
        in_valid = 1'b1; op_code = op; is_alu64 = a64; src_bit = src; imm = im; dst_in = d;
    endtask

    // one operation, then read both copies on the next falling edge
    task automatic run_one(string req, logic [3:0] op, bit a64, bit src,
                           logic [31:0] im, logic [63:0] d);
        logic [64:0] e_le, e_be;
        e_le = expect_of(1'b0, op, a64, src, im, d);
        e_be = expect_of(1'b1, op, a64, src, im, d);
        drive(op, a64, src, im, d);
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " le valid"}, {63'd0, le_valid}, 64'd1);
        check({req, " le data"},  le_dst, e_le[63:0]);
        check({req, " le flag"},  {63'd0, le_ill}, {63'd0, e_le[64]});
        check({req, " be data"},  be_dst, e_be[63:0]);
        check({req, " be flag"},  {63'd0, be_ill}, {63'd0, e_be[64]});
    endtask

    localparam logic [63:0] PAT_A = 64'h1122_3344_5566_7788;
    localparam logic [63:0] PAT_B = 64'hF0E1_D2C3_B4A5_9687;

    task automatic t_reset;
        check("R1 valid", {63'd0, le_valid}, 64'd0);
        check("R1 data",  le_dst, 64'd0);
        check("R1 flag",  {63'd0, le_ill}, 64'd0);
    endtask

    task automatic t_little_target;
        run_one("R3 w16", 4'hd, 1'b0, 1'b0, 32'd16, PAT_A);
        run_one("R3 w32", 4'hd, 1'b0, 1'b0, 32'd32, PAT_B);
        run_one("R3 w64", 4'hd, 1'b0, 1'b0, 32'd64, PAT_A);
        check("R3 literal le", le_dst, PAT_A);
    endtask

    task automatic t_big_target;
        run_one("R4 w16", 4'hd, 1'b0, 1'b1, 32'd16, PAT_B);
        run_one("R4 w32", 4'hd, 1'b0, 1'b1, 32'd32, PAT_A);
        check("R4 literal le", le_dst, 64'h0000_0000_8877_6655);
        check("R4 literal be", be_dst, 64'h0000_0000_5566_7788);
    endtask

    task automatic t_wide_class;
        run_one("R5 w64", 4'hd, 1'b1, 1'b0, 32'd64, PAT_A);
        check("R5 literal be", be_dst, 64'h8877_6655_4433_2211);
        run_one("R5 w32", 4'hd, 1'b1, 1'b0, 32'd32, PAT_B);
    endtask

    task automatic t_widths;
        run_one("R6 w16", 4'hd, 1'b1, 1'b0, 32'd16, PAT_A);
        check("R6 literal", le_dst, 64'h0000_0000_0000_8877);
        run_one("R6 w32", 4'hd, 1'b1, 1'b0, 32'd32, 64'hFFFF_FFFF_0102_0304);
        check("R6 literal32", le_dst, 64'h0000_0000_0403_0201);
        run_one("R7 w64", 4'hd, 1'b1, 1'b0, 32'd64, 64'h0001_0203_0405_0607);
        check("R7 literal", be_dst, 64'h0706_0504_0302_0100);
    endtask

    task automatic t_bad_imm;
        run_one("R8 imm8",  4'hd, 1'b0, 1'b0, 32'd8,  PAT_A);
        run_one("R8 imm0",  4'hd, 1'b1, 1'b0, 32'd0,  PAT_B);
        run_one("R8 immhi", 4'hd, 1'b0, 1'b1, 32'h1_0010, PAT_A);
        check("R8 literal", {63'd0, le_ill}, 64'd1);
    endtask

    task automatic t_reserved;
        run_one("R9 w64", 4'hd, 1'b1, 1'b1, 32'd64, PAT_A);
        run_one("R9 w16", 4'hd, 1'b1, 1'b1, 32'd16, PAT_B);
        check("R9 literal", le_dst, PAT_B);
    endtask

    task automatic t_other_op;
        run_one("R10 add", 4'h0, 1'b1, 1'b0, 32'd64, PAT_A);
        run_one("R10 arsh", 4'hc, 1'b0, 1'b1, 32'd7, PAT_B);
        check("R10 literal", {63'd0, be_ill}, 64'd0);
    endtask

    task automatic t_idle_hold;
        run_one("R11 setup", 4'hd, 1'b1, 1'b1, 32'd64, PAT_A);
        @(negedge clk);
        op_code = 4'hd; is_alu64 = 1'b0; src_bit = 1'b1; imm = 32'd16; dst_in = PAT_B;
        @(negedge clk);
        @(negedge clk);
        check("R11 data", le_dst, PAT_A);
        check("R11 flag", {63'd0, le_ill}, 64'd1);
        check("R2 idle valid", {63'd0, le_valid}, 64'd0);
    endtask

    task automatic t_back_to_back;
        logic [64:0] e1, e2;
        e1 = expect_of(1'b0, 4'hd, 1'b0, 1'b1, 32'd16, PAT_A);
        e2 = expect_of(1'b0, 4'hd, 1'b1, 1'b0, 32'd64, PAT_B);
        drive(4'hd, 1'b0, 1'b1, 32'd16, PAT_A);
        drive(4'hd, 1'b1, 1'b0, 32'd64, PAT_B);
        check("R2 first valid", {63'd0, le_valid}, 64'd1);
        check("R2 first data", le_dst, e1[63:0]);
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 second data", le_dst, e2[63:0]);
        @(negedge clk);
        check("R2 drop valid", {63'd0, le_valid}, 64'd0);
    endtask

    initial begin
        #1;
        t_reset();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_little_target();
        t_big_target();
        t_wide_class();
        t_widths();
        t_bad_imm();
        t_reserved();
        t_other_op();
        t_idle_hold();
        t_back_to_back();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule